// File: doc/BRIEF.md
# Half-Duplex Collision Backoff and Retry Controller

This block sits beside the transmit path of a half-duplex Ethernet MAC and decides when a frame that was aborted by a collision may be sent again. Each collision abort raises the attempt number n. A random whole number of slot times r, with 0 <= r < 2^min(n,10), is then drawn from a free-running 32-bit LFSR. The block waits out r slots and grants a one-cycle retry strobe as soon as the inter-packet gap is also satisfied.

Identical MACs would otherwise draw identical sequences. To break that, the LFSR takes as its new seed the 32-bit CRC of every frame that leaves without error. If a frame collides more than sixteen times, or the transmit FIFO underruns, the frame is dropped with a discard strobe and the attempt count returns to zero for the next queued frame. A separate error strobe marks the excessive-collision case so that a status bit or interrupt can be raised elsewhere.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `attempt_o` is 0 and `retry_go_o`, `discard_o` and `excess_err_o` are low.
- R2: A collision pulse taken while no backoff is pending raises `attempt_o` by one at that clock edge and starts a backoff. A collision pulse that arrives while a backoff is pending or granted but not yet used changes nothing.
- R3: `retry_go_o` is high for exactly one cycle, and only after a cycle in which `ipg_ok_i` was high. When the backoff has run out while `ipg_ok_i` is low, the grant is held back and issued on the first edge that sees `ipg_ok_i` high.
- R4: With `ipg_ok_i` held high, `retry_go_o` rises 2 + r*SLOT_CYCLES clock edges after the edge that took the collision, where r is an integer with 0 <= r < 2^min(n,10) and n is the new attempt count.
- R5: A collision taken while `attempt_o` is 16 does not retry. At that edge `discard_o` and `excess_err_o` pulse for one cycle and `attempt_o` goes to 0.
- R6: An underrun pulse in any state pulses `discard_o` with `excess_err_o` low, clears `attempt_o`, and cancels any pending backoff so that no `retry_go_o` follows. An underrun takes priority over a collision in the same cycle.
- R7: A success pulse `tx_ok_i` clears `attempt_o` to 0 and cancels any pending backoff.
- R8: A success pulse loads `tx_crc_i` as the LFSR seed. The same seed, followed by the same cycle-by-cycle stimulus, yields the same backoff delays.
- R9: A seed of zero is replaced by a fixed non-zero value, so the generator never locks at zero and later draws are not all zero.
- R10: A success pulse and a collision pulse in the same cycle act as a success: `attempt_o` is 0 and no backoff or grant follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (the RMII reference clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| coll_abort_i | input | 1 | One-cycle pulse: the current attempt was aborted by a collision |
| underrun_i | input | 1 | One-cycle pulse: the transmit FIFO ran dry and the frame is lost |
| tx_ok_i | input | 1 | One-cycle pulse: a frame was sent without error |
| tx_crc_i | input | 32 | CRC of that frame, valid with `tx_ok_i` |
| ipg_ok_i | input | 1 | High while the inter-packet gap is satisfied |
| retry_go_o | output | 1 | One-cycle grant to resend the frame |
| discard_o | output | 1 | One-cycle strobe: drop the frame and move on to the next |
| excess_err_o | output | 1 | One-cycle strobe: the drop was caused by excessive collisions |
| attempt_o | output | 5 | Number of collisions taken for the current frame |

## Verification
Several events can fall in the same clock cycle. The two pairs that matter most are an abort that lands together with an underrun, and an abort that lands together with a success pulse. The bench drives each pair on the same edge, with the attempt count already non-zero. For the first pair it expects a plain discard with the error strobe low. For the second it expects a silent clear with no discard. In both cases it then watches for longer than the largest possible backoff and confirms that no grant appears. A third overlap comes from the free-running generator: it steps on the same edge that a success pulse reseeds it. The bench judges this overlap by replaying an identical seed and stimulus and comparing the delays it measures.

// File: rtl/bko_pkg.sv
// Package: shared types and helpers for the collision backoff controller.
// Assumes: nothing beyond IEEE 1800-2017.
package bko_pkg;

    // Controller phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no backoff pending; collisions are accepted
        ST_WAIT  = 2'd1,   // slot timer is running
        ST_READY = 2'd2    // backoff over, waiting on the inter-packet gap
    } bko_state_e;

    // Smaller of two integers, used for derived widths
    function automatic int bko_min(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Width of a counter that must hold 0..n-1, never below 1
    function automatic int bko_cw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bko_lfsr.sv
// Module: bko_lfsr
// Free-running Galois LFSR that steps on every clock. On load_i it takes
// seed_i as its new state. A zero seed is swapped for FALLBACK so the
// register can never stick at zero.
// Assumes: POLY and FALLBACK are non-zero.
module bko_lfsr #(
    parameter int          W        = 32,
    parameter logic [W-1:0] POLY     = 32'h8020_0003,
    parameter logic [W-1:0] FALLBACK = 32'h1D87_2B41
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_q;
    logic [W-1:0] step_val;
    logic [W-1:0] seed_val;

    // One Galois step: shift left and fold the taps back in on a carry-out
    always_comb begin
        step_val = {state_q[W-2:0], 1'b0};
        if (state_q[W-1]) begin
            step_val = step_val ^ POLY;
        end
    end

    // Replace a zero seed with the fallback constant
    always_comb begin
        seed_val = (seed_i == '0) ? FALLBACK : seed_i;
    end

    // Register: reseed on load, otherwise advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FALLBACK;
        end else if (load_i) begin
            state_q <= seed_val;
        end else begin
            state_q <= step_val;
        end
    end

    assign state_o = state_q;

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);  // R9

    AST_LFSR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> state_q == $past(seed_i));  // R8

endmodule

// File: rtl/bko_slot_timer.sv
// Module: bko_slot_timer
// Counts a requested number of slot times, each SLOT_CYCLES clocks long.
// start_i loads the slot count and restarts the cycle counter. expired_o
// is high whenever no slots are left.
// Assumes: start_i is only raised by the owner when a new wait begins.
module bko_slot_timer #(
    parameter int SLOT_CYCLES = 256,
    parameter int SLOT_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SLOT_W-1:0] slots_i,
    output logic              expired_o
);
    import bko_pkg::*;

    localparam int                CYC_W    = bko_cw(SLOT_CYCLES);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYCLES - 1);

    logic [SLOT_W-1:0] slots_q;
    logic [CYC_W-1:0]  cyc_q;

    // Load on start; otherwise count cycles down and give up a slot on each wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
            cyc_q   <= CYC_LAST;
        end else if (start_i) begin
            slots_q <= slots_i;
            cyc_q   <= CYC_LAST;
        end else if (slots_q != '0) begin
            if (cyc_q == '0) begin
                slots_q <= slots_q - 1'b1;
                cyc_q   <= CYC_LAST;
            end else begin
                cyc_q   <= cyc_q - 1'b1;
            end
        end
    end

    assign expired_o = (slots_q == '0);

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && slots_q != '0) |=> slots_q <= $past(slots_q));  // R4

    AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && slots_q == '0) |=> slots_q == '0);  // R4

endmodule

// File: rtl/bko_attempt_ctr.sv
// Module: bko_attempt_ctr
// Counts collisions for the frame now in flight. Clearing takes priority
// over counting. at_limit_o reports that the count has reached MAX_ATTEMPTS.
// Assumes: the owner never raises inc_i while at_limit_o is high.
module bko_attempt_ctr #(
    parameter int MAX_ATTEMPTS = 16,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             at_limit_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ATTEMPTS);

    logic [CNT_W-1:0] count_q;

    // Count register: clear wins over increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o    = count_q;
    assign at_limit_o = (count_q == LIMIT);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LIMIT);  // R5

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_q == '0);  // R7

endmodule

// File: rtl/csma_backoff_ctrl.sv
// Module: csma_backoff_ctrl (top)
// Collision backoff and retry controller for a half-duplex MAC. It takes
// collision, underrun and success pulses. It draws a truncated binary
// exponential backoff from a CRC-seeded LFSR, times it in slots, and
// grants a retry once the inter-packet gap is also satisfied.
// Assumes: input pulses are one cycle long and synchronous to clk. A
// collision is only meaningful while no backoff is pending.
module csma_backoff_ctrl
    import bko_pkg::*;
#(
    parameter int          SLOT_CYCLES   = 256,
    parameter int          MAX_ATTEMPTS  = 16,
    parameter int          BACKOFF_LIMIT = 10,
    parameter logic [31:0] LFSR_POLY     = 32'h8020_0003,
    parameter logic [31:0] LFSR_FALLBACK = 32'h1D87_2B41,
    parameter int          CNT_W         = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coll_abort_i,
    input  logic             underrun_i,
    input  logic             tx_ok_i,
    input  logic [31:0]      tx_crc_i,
    input  logic             ipg_ok_i,
    output logic             retry_go_o,
    output logic             discard_o,
    output logic             excess_err_o,
    output logic [CNT_W-1:0] attempt_o
);

    localparam int SLOT_W = BACKOFF_LIMIT;

    bko_state_e        st_q;
    logic [31:0]       rnd;
    logic [CNT_W-1:0]  attempt;
    logic [CNT_W-1:0]  next_attempt;
    logic              at_limit;
    logic              expired;
    logic              coll_take;
    logic              excess;
    logic              bo_start;
    logic              cnt_clr;
    logic              abandon;
    logic [SLOT_W-1:0] draw_mask;
    logic [SLOT_W-1:0] draw_slots;

    // Decode of the incoming pulses, in priority order: underrun, success, collision
    always_comb begin
        coll_take = coll_abort_i && (st_q == ST_IDLE) && !underrun_i && !tx_ok_i;
        excess    = coll_take && at_limit;
        bo_start  = coll_take && !at_limit;
        cnt_clr   = underrun_i || tx_ok_i || excess;
        abandon   = underrun_i || tx_ok_i || excess;
    end

    // Attempt number that this collision brings the count to
    assign next_attempt = attempt + 1'b1;

    // Mask bit i is set when the exponent min(n, limit) is above i
    generate
        for (genvar gi = 0; gi < SLOT_W; gi++) begin : g_mask
            assign draw_mask[gi] = (int'(next_attempt) > gi);
        end
    endgenerate

    // Random slot count, truncated to the current exponent
    assign draw_slots = rnd[SLOT_W-1:0] & draw_mask;

    bko_lfsr #(
        .W        (32),
        .POLY     (LFSR_POLY),
        .FALLBACK (LFSR_FALLBACK)
    ) i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tx_ok_i),
        .seed_i  (tx_crc_i),
        .state_o (rnd)
    );

    bko_attempt_ctr #(
        .MAX_ATTEMPTS (MAX_ATTEMPTS),
        .CNT_W        (CNT_W)
    ) i_attempt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (bo_start),
        .clr_i      (cnt_clr),
        .count_o    (attempt),
        .at_limit_o (at_limit)
    );

    bko_slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .SLOT_W      (SLOT_W)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (bo_start),
        .slots_i   (draw_slots),
        .expired_o (expired)
    );

    // Phase register: idle, then timing, then waiting on the gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (abandon) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (bo_start) st_q <= ST_WAIT;
                ST_WAIT:  if (expired)  st_q <= ST_READY;
                ST_READY: if (ipg_ok_i) st_q <= ST_IDLE;
                default:                st_q <= ST_IDLE;
            endcase
        end
    end

    // Registered strobes: grant, discard and the excessive-collision error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_go_o   <= 1'b0;
            discard_o    <= 1'b0;
            excess_err_o <= 1'b0;
        end else begin
            retry_go_o   <= (st_q == ST_READY) && ipg_ok_i && !underrun_i && !tx_ok_i;
            discard_o    <= underrun_i || excess;
            excess_err_o <= excess;
        end
    end

    assign attempt_o = attempt;

    AST_COLL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && coll_abort_i && !underrun_i && !tx_ok_i && !at_limit)
        |=> attempt_o == $past(attempt_o) + 1'b1);  // R2

    AST_COLL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !underrun_i && !tx_ok_i) |=> attempt_o == $past(attempt_o));  // R2

    AST_GO_NEEDS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        retry_go_o |-> $past(ipg_ok_i));  // R3

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_go_o |=> !retry_go_o);  // R3

    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY && !ipg_ok_i && !underrun_i && !tx_ok_i)
        |=> (!retry_go_o && st_q == ST_READY));  // R3

    AST_EXCESS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        excess_err_o |-> (discard_o && attempt_o == '0));  // R5

    AST_UNDERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_i |=> (discard_o && !excess_err_o && !retry_go_o && attempt_o == '0));  // R6

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_go_o && discard_o));  // R6

    AST_OK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ok_i && !underrun_i) |=> (attempt_o == '0 && !discard_o && !retry_go_o));  // R10

endmodule

// File: tb/test_csma_backoff_ctrl.sv
module test_csma_backoff_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 4;
    localparam int MAXA       = 16;
    localparam int LIM        = 10;
    localparam int WAIT_CAP   = 2 + (1 << LIM) * SLOT + 20;

    // Table: seed, number of back-to-back collisions, expected final count
    localparam int          NVEC = 5;
    localparam logic [31:0] VEC_SEED  [NVEC] = '{32'hC704_DD7B, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0001, 32'hDEAD_BEEF};
    localparam int          VEC_COLLS [NVEC] = '{1, 3, 6, 2, 11};
    localparam int          VEC_EXP   [NVEC] = '{1, 3, 6, 2, 11};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coll_abort_i = 1'b0;
    logic        underrun_i = 1'b0;
    logic        tx_ok_i = 1'b0;
    logic [31:0] tx_crc_i = '0;
    logic        ipg_ok_i = 1'b1;
    logic        retry_go_o;
    logic        discard_o;
    logic        excess_err_o;
    logic [4:0]  attempt_o;

    int total = 0;
    int bad   = 0;

    csma_backoff_ctrl #(
        .SLOT_CYCLES   (SLOT),
        .MAX_ATTEMPTS  (MAXA),
        .BACKOFF_LIMIT (LIM)
    ) i_csma_backoff_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .coll_abort_i (coll_abort_i),
        .underrun_i   (underrun_i),
        .tx_ok_i      (tx_ok_i),
        .tx_crc_i     (tx_crc_i),
        .ipg_ok_i     (ipg_ok_i),
        .retry_go_o   (retry_go_o),
        .discard_o    (discard_o),
        .excess_err_o (excess_err_o),
        .attempt_o    (attempt_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one edge and settle away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reseed(input logic [31:0] crc);
        tx_crc_i = crc;
        tx_ok_i  = 1'b1;
        tick();
        tx_ok_i  = 1'b0;
    endtask

    // Collide once, then measure the edges until the grant (ipg held high)
    task automatic collide_measure(input int n, output int d);
        int lim;
        coll_abort_i = 1'b1;
        tick();
        coll_abort_i = 1'b0;
        check(attempt_o == 5'(n), "R2 count after collision", attempt_o, n);
        d = 0;
        while (!retry_go_o && d < WAIT_CAP) begin
            tick();
            d++;
        end
        lim = 1 << ((n < LIM) ? n : LIM);
        check(retry_go_o && d >= 2 && ((d - 2) % SLOT) == 0 && ((d - 2) / SLOT) < lim,
              "R4 backoff delay", d, 2 + (lim - 1) * SLOT);
    endtask

    // Watch a window and count any grant
    task automatic watch_no_go(input int cycles, input string req);
        int seen = 0;
        for (int k = 0; k < cycles; k++) begin
            tick();
            if (retry_go_o) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d;
        int dl_a [4];
        int dl_b [4];
        int nonzero;

        // R1: reset state
        repeat (3) tick();
        check(attempt_o == 0 && !retry_go_o && !discard_o && !excess_err_o,
              "R1 reset outputs", {attempt_o, retry_go_o, discard_o, excess_err_o}, 0);
        rst_n = 1'b1;
        tick();

        // Vector table walk: R4 delays and R2 counting, then R7 clear
        for (int v = 0; v < NVEC; v++) begin
            reseed(VEC_SEED[v]);
            for (int c = 1; c <= VEC_COLLS[v]; c++) begin
                collide_measure(c, d);
            end
            check(attempt_o == 5'(VEC_EXP[v]), "R2 final count", attempt_o, VEC_EXP[v]);
            reseed(32'h0BAD_F00D + 32'(v));
            check(attempt_o == 0, "R7 success clears count", attempt_o, 0);
        end

        // R3 and R2: gap low holds the grant back, extra collisions ignored
        ipg_ok_i = 1'b0;
        coll_abort_i = 1'b1;
        tick();
        coll_abort_i = 1'b0;
        tick();
        coll_abort_i = 1'b1;
        tick();
        coll_abort_i = 1'b0;
        check(attempt_o == 1, "R2 collision while waiting ignored", attempt_o, 1);
        watch_no_go(2 * SLOT + 6, "R3 no grant while gap low");
        check(attempt_o == 1, "R2 count held while waiting", attempt_o, 1);
        ipg_ok_i = 1'b1;
        tick();
        check(retry_go_o == 1'b1, "R3 grant on gap", retry_go_o, 1);
        tick();
        check(retry_go_o == 1'b0, "R3 grant is one cycle", retry_go_o, 0);

        // R6: underrun during a pending backoff cancels it
        reseed(32'h5555_AAAA);
        collide_measure(1, d);
        collide_measure(2, d);
        coll_abort_i = 1'b1;
        tick();
        coll_abort_i = 1'b0;
        underrun_i = 1'b1;
        tick();
        underrun_i = 1'b0;
        check(discard_o && !excess_err_o && attempt_o == 0, "R6 underrun discard",
              {discard_o, excess_err_o, attempt_o}, 32'h40);
        tick();
        check(!discard_o, "R6 discard is one cycle", discard_o, 0);
        watch_no_go(10 * SLOT, "R6 no grant after underrun");

        // R6: underrun and collision in the same cycle
        collide_measure(1, d);
        coll_abort_i = 1'b1;
        underrun_i   = 1'b1;
        tick();
        coll_abort_i = 1'b0;
        underrun_i   = 1'b0;
        check(discard_o && !excess_err_o && attempt_o == 0, "R6 underrun beats collision",
              {discard_o, excess_err_o, attempt_o}, 32'h40);
        watch_no_go(10 * SLOT, "R6 no grant after same-cycle underrun");

        // R10: success and collision in the same cycle
        collide_measure(1, d);
        coll_abort_i = 1'b1;
        tx_crc_i     = 32'h0F0F_0F0F;
        tx_ok_i      = 1'b1;
        tick();
        coll_abort_i = 1'b0;
        tx_ok_i      = 1'b0;
        check(attempt_o == 0 && !discard_o, "R10 success beats collision",
              {attempt_o, discard_o}, 0);
        watch_no_go(10 * SLOT, "R10 no grant after same-cycle success");

        // R8: identical seed and stimulus give identical delays
        reseed(32'h3C3C_9A9A);
        repeat (3) tick();
        for (int c = 0; c < 4; c++) collide_measure(c + 1, dl_a[c]);
        reseed(32'h3C3C_9A9A);
        repeat (3) tick();
        for (int c = 0; c < 4; c++) collide_measure(c + 1, dl_b[c]);
        for (int c = 0; c < 4; c++) begin
            check(dl_a[c] == dl_b[c], "R8 reseed repeats delays", dl_b[c], dl_a[c]);
        end

        // R9: zero seed still yields some non-zero draws
        reseed(32'h0);
        nonzero = 0;
        for (int c = 1; c <= 8; c++) begin
            collide_measure(c, d);
            if (d != 2) nonzero++;
        end
        check(nonzero > 0, "R9 zero seed not locked", nonzero, 1);

        // R5: seventeenth collision discards with the error strobe
        reseed(32'h7777_1111);
        for (int c = 1; c <= MAXA; c++) collide_measure(c, d);
        check(attempt_o == 5'(MAXA), "R5 count at limit", attempt_o, MAXA);
        coll_abort_i = 1'b1;
        tick();
        coll_abort_i = 1'b0;
        check(discard_o && excess_err_o && attempt_o == 0, "R5 excessive discard",
              {discard_o, excess_err_o, attempt_o}, 32'h60);
        tick();
        check(!discard_o && !excess_err_o, "R5 strobes one cycle",
              {discard_o, excess_err_o}, 0);
        watch_no_go(10 * SLOT, "R5 no retry after excess");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule